// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit characters over a data-out line and a data-in line. A single serial clock paces both lines. Each character goes out least significant bit first, with no framing, parity or address bit. The transmitter and the receiver share that clock and run at the same time. Transmit data changes on a falling clock edge. Receive data is taken on a rising edge.

The serial clock has two possible sources, chosen by a mode input. In internal mode a programmable divider makes the clock and drives it out, and the clock runs only while there is something to send. In external mode a clock arrives on an input pin and is resynchronised to the system clock. Each direction has a holding register in front of its shift register. The host can queue the next byte, or collect the last one, while a character is still in flight. A queued byte follows the previous one with no pause in the clock. A host register interface gives the transmit-empty, receive-full and overrun flags.

Top module: `sync_serial_port`

## Requirements
- R1: Every character is exactly 8 serial clock pulses (8 falling and 8 rising edges) and carries 8 data bits, bit 0 first and bit 7 last, with nothing added.
- R2: `txd_o` changes only on a falling edge of the serial clock and holds its value until the next falling edge.
- R3: The receiver takes the level of the data input at the rising edge of the serial clock. A level present only away from that edge has no effect.
- R4: Out of reset, `sclk_o`=1, `txd_o`=1, `tx_empty_o`=1, `rx_full_o`=0 and `rx_ovr_o`=0. When no further byte is queued at the end of a character, the serial clock rests high and `txd_o` keeps the level of bit 7 of that character.
- R5: With `clk_src_i`=0 (internal), `sclk_oe_o`=1 and each clock phase, high or low, lasts `div_half_i`+1 system clocks.
- R6: With `clk_src_i`=1 (external), `sclk_oe_o`=0 and `sclk_o`=1. The edges of `sclk_i` are brought in through a 2-stage synchroniser, and the port shifts data in and out on them.
- R7: A write pulse on `tx_wr_i` clears `tx_empty_o`. `tx_empty_o` is set again when the held byte moves into the shift register at the first falling edge of its character. A write while `tx_empty_o`=0 is ignored.
- R8: When a byte is already queued as a character ends, the high phase between the two characters is one ordinary half period (`div_half_i`+1 clocks).
- R9: When a received byte is complete it is copied to `rx_data_o` and `rx_full_o` is set. A pulse on `rx_rd_i` clears `rx_full_o`. `rx_data_o` holds while `rx_full_o` is set.
- R10: If a byte completes while `rx_full_o`=1 and no read occurs in that cycle, the new byte is discarded and `rx_ovr_o` is set. `rx_ovr_o` stays set until a pulse on `ovr_clr_i`.
- R11: The receiver works while the transmitter is shifting, from the same clock edges. In internal mode a byte looped from `txd_o` back to `rxd_i` arrives unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_src_i | input | 1 | Serial clock source: 0 internal divider, 1 external pin |
| div_half_i | input | DIV_W | Half-period setting N; each phase lasts N+1 clocks |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Generated serial clock, high when idle |
| sclk_oe_o | output | 1 | Drive enable for the clock pin, 1 in internal mode |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | W | Byte to transmit |
| tx_empty_o | output | 1 | Transmit holding register can take a byte |
| rx_rd_i | input | 1 | Read strobe, clears the receive-full flag |
| rx_data_o | output | W | Last received byte |
| rx_full_o | output | 1 | Received byte waiting |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rx_ovr_o | output | 1 | A byte was lost to overrun |

## Verification
The assertions check the following on every cycle:
- the transmit line moves only in a cycle that follows a falling-edge event;
- the empty and full flags rise only after the matching clock edge;
- a waiting receive byte is never overwritten;
- an overrun flag rises only over a full buffer;
- an idle internal clock stays high;
- the rising and falling events never coincide.

Only the scenarios can show:
- bit order and byte contents;
- the exact half-period lengths and the gapless step from one character to the next;
- that a write to a full buffer is ignored;
- that the receiver samples at the rising edge and not elsewhere in the bit;
- the complete external-clock exchange.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  parameter int unsigned SSP_BITS = 8;
  typedef logic [SSP_BITS-1:0] ssp_word_t;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} ssp_src_e;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_i,
  input  logic [DIV_W-1:0] div_half_i,
  input  logic             more_i,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             fall_o,
  output logic             rise_o
);
  logic [DIV_W-1:0]     cnt_q;
  logic                 sclk_q;
  logic [SYNC_STAGES:0] sync_q;
  logic                 tc, park;
  logic                 int_fall, int_rise, ext_fall, ext_rise;

  // synchroniser chain plus one stage for edge detection
  for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b1;
        else         sync_q[0] <= sclk_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b1;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign ext_fall = ext_i &&  sync_q[SYNC_STAGES] && !sync_q[SYNC_STAGES-1];
  assign ext_rise = ext_i && !sync_q[SYNC_STAGES] &&  sync_q[SYNC_STAGES-1];

  assign tc   = (cnt_q == div_half_i);
  assign park = sclk_q && !more_i;   // idle: rest high, divider held

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (ext_i || park) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tc) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end

  assign int_fall = !ext_i && !park && tc &&  sclk_q;
  assign int_rise = !ext_i &&          tc && !sclk_q;

  assign fall_o    = int_fall | ext_fall;
  assign rise_o    = int_rise | ext_rise;
  assign sclk_o    = sclk_q;
  assign sclk_oe_o = !ext_i;

  always_comb begin
    if (rst_ni) begin
      a_r1_edge_exclusive: assert (!(fall_o && rise_o));
    end
  end

  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_i && !more_i && sclk_q) |=> sclk_q);
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_i,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic         empty_o,
  output logic         more_o,
  output logic         txd_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  hold_q, sh_q;
  logic [CW-1:0] bits_q;
  logic          full_q, act_q, txd_q;
  logic          last, load;

  assign last = (bits_q == CW'(W));
  assign load = fall_i && (!act_q || last) && full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bits_q <= '0;
      act_q  <= 1'b0;
      txd_q  <= 1'b1;
    end else if (fall_i) begin
      if (!act_q || last) begin
        if (full_q) begin
          txd_q  <= hold_q[0];
          sh_q   <= hold_q >> 1;
          bits_q <= CW'(1);
          act_q  <= 1'b1;
        end else begin
          act_q  <= 1'b0;   // line keeps last bit
        end
      end else begin
        txd_q  <= sh_q[0];
        sh_q   <= sh_q >> 1;
        bits_q <= bits_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      hold_q <= data_i;
      full_q <= 1'b1;
    end
  end

  assign empty_o = !full_q;
  assign more_o  = full_q || (act_q && !last);
  assign txd_o   = txd_q;

  a_r2_txd_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_q) |-> $past(fall_i));
  a_r7_empty_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> $past(fall_i));
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ext_i,
  input  logic         rise_i,
  input  logic         rxd_i,
  input  logic         rd_i,
  input  logic         ovr_clr_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         ovr_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [SYNC_STAGES-1:0] rsync_q;
  logic [W-1:0]           sh_q, data_q, next_word;
  logic [CW-1:0]          cnt_q;
  logic                   full_q, ovr_q, bit_in, done;

  // delay matches the clock synchroniser in external mode
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_rsync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) rsync_q[0] <= 1'b1;
        else         rsync_q[0] <= rxd_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) rsync_q[i] <= 1'b1;
        else         rsync_q[i] <= rsync_q[i-1];
    end
  end

  assign bit_in    = ext_i ? rsync_q[SYNC_STAGES-1] : rxd_i;
  assign next_word = {bit_in, sh_q[W-1:1]};
  assign done      = rise_i && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (rise_i) begin
      sh_q  <= next_word;
      cnt_q <= done ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (done && (!full_q || rd_i)) begin
        data_q <= next_word;
        full_q <= 1'b1;
      end else if (rd_i) begin
        full_q <= 1'b0;
      end
      if (done && full_q && !rd_i) ovr_q <= 1'b1;
      else if (ovr_clr_i)          ovr_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;

  a_r9_full_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_q) |-> $past(rise_i));
  a_r10_keep_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !rd_i) |=> $stable(data_q));
  a_r10_ovr_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_q) |-> $past(full_q));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int W           = SSP_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_src_i,
  input  logic [DIV_W-1:0] div_half_i,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             txd_o,
  input  logic             rxd_i,
  input  logic             tx_wr_i,
  input  logic [W-1:0]     tx_data_i,
  output logic             tx_empty_o,
  input  logic             rx_rd_i,
  output logic [W-1:0]     rx_data_o,
  output logic             rx_full_o,
  input  logic             ovr_clr_i,
  output logic             rx_ovr_o
);
  logic ext, fall, rise, more;

  assign ext = (ssp_src_e'(clk_src_i) == SRC_EXT);

  ssp_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk_i, .rst_ni,
    .ext_i      (ext),
    .div_half_i,
    .more_i     (more),
    .sclk_i,
    .sclk_o,
    .sclk_oe_o,
    .fall_o     (fall),
    .rise_o     (rise)
  );

  ssp_tx #(.W(W)) u_tx (
    .clk_i, .rst_ni,
    .fall_i  (fall),
    .wr_i    (tx_wr_i),
    .data_i  (tx_data_i),
    .empty_o (tx_empty_o),
    .more_o  (more),
    .txd_o
  );

  ssp_rx #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni,
    .ext_i     (ext),
    .rise_i    (rise),
    .rxd_i,
    .rd_i      (rx_rd_i),
    .ovr_clr_i,
    .data_o    (rx_data_o),
    .full_o    (rx_full_o),
    .ovr_o     (rx_ovr_o)
  );
endmodule

// File: tb/sync_serial_port_bench.sv
`timescale 1ns/1ps
module sync_serial_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       src = 1'b0;
  logic [7:0] div = 8'd3;
  logic       m_sclk = 1'b1, m_rxd = 1'b1, loop_en = 1'b1;
  logic       wr = 1'b0, man_rd = 1'b0, auto_rd = 1'b0, ovr_clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       sclk, sclk_oe, txd, rxd, tx_empty, rx_full, rx_ovr, rd;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic mon_en = 1'b1, b2b_en = 1'b0, arm = 1'b0;
  logic prev_sclk = 1'b1, prev_txd = 1'b1;
  int half = 0, bitn = 0;
  logic [7:0] mon_byte = 8'h00;
  logic auto_pulse = 1'b0;

  always #4 clk = ~clk;

  assign rxd = loop_en ? txd : m_rxd;
  assign rd  = man_rd | auto_pulse;

  sync_serial_port u_sync_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .clk_src_i(src), .div_half_i(div),
    .sclk_i(m_sclk), .sclk_o(sclk), .sclk_oe_o(sclk_oe), .txd_o(txd),
    .rxd_i(rxd), .tx_wr_i(wr), .tx_data_i(wdata), .tx_empty_o(tx_empty),
    .rx_rd_i(rd), .rx_data_o(rx_data), .rx_full_o(rx_full),
    .ovr_clr_i(ovr_clr), .rx_ovr_o(rx_ovr)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] b);
    @(negedge clk); wr = 1'b1; wdata = b;
    @(negedge clk); wr = 1'b0;
  endtask

  // driver: queue expectations, then write
  task automatic send(input logic [7:0] b, input logic expect_rx);
    tx_q.push_back(b);
    if (expect_rx) rx_q.push_back(b);
    poke(b);
  endtask

  task automatic wait_idle();
    int run = 0;
    while (run < 2 * (int'(div) + 1) + 4) begin
      @(negedge clk);
      if (sclk && tx_empty) run++; else run = 0;
    end
  endtask

  // monitor: serial line timing and transmitted bytes
  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (txd != prev_txd)
        chk(prev_sclk && !sclk, "R2 txd moved off falling edge", int'(sclk), 0);
      if (sclk != prev_sclk) begin
        if (!prev_sclk) begin
          chk(half == int'(div) + 1, "R5 low phase", half, int'(div) + 1);
          mon_byte = {txd, mon_byte[7:1]};
          bitn++;
          if (bitn == 8) begin
            if (tx_q.size() == 0) chk(1'b0, "R1 unexpected character", int'(mon_byte), 0);
            else begin
              automatic logic [7:0] e = tx_q.pop_front();
              chk(mon_byte == e, "R1 transmitted byte", int'(mon_byte), int'(e));
            end
            bitn = 0;
            if (b2b_en) arm = 1'b1;
          end
        end else begin
          if (bitn != 0) chk(half == int'(div) + 1, "R5 high phase", half, int'(div) + 1);
          else if (arm) chk(half == int'(div) + 1, "R8 gap between characters", half, int'(div) + 1);
          arm = 1'b0;
        end
        half = 1;
      end else half++;
    end
    prev_sclk = sclk;
    prev_txd  = txd;
  end

  // receive scoreboard: read and compare whenever a byte waits
  always @(negedge clk) begin
    if (auto_pulse) auto_pulse = 1'b0;
    else if (rst_n && auto_rd && rx_full) begin
      if (rx_q.size() == 0) chk(1'b0, "R11 unexpected rx byte", int'(rx_data), 0);
      else begin
        automatic logic [7:0] e = rx_q.pop_front();
        chk(rx_data == e, "R11 looped byte", int'(rx_data), int'(e));
      end
      auto_pulse = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1, "R4 reset sclk", int'(sclk), 1);
    chk(txd == 1'b1, "R4 reset txd", int'(txd), 1);
    chk(tx_empty == 1'b1, "R4 reset tx_empty", int'(tx_empty), 1);
    chk(rx_full == 1'b0, "R4 reset rx_full", int'(rx_full), 0);
    chk(rx_ovr == 1'b0, "R4 reset rx_ovr", int'(rx_ovr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sclk_oe == 1'b1, "R5 internal drives clock", int'(sclk_oe), 1);

    // internal mode, loopback
    auto_rd = 1'b1;
    send(8'hA5, 1'b1);
    wait_idle();
    chk(txd == 1'b1, "R4 holds MSB 1", int'(txd), 1);
    send(8'h3C, 1'b1);
    wait_idle();
    chk(txd == 1'b0, "R4 holds MSB 0", int'(txd), 0);
    chk(sclk == 1'b1, "R4 idle clock high", int'(sclk), 1);

    // write to full holding register ignored
    send(8'h11, 1'b1);
    chk(tx_empty == 1'b0, "R7 write clears empty", int'(tx_empty), 0);
    poke(8'h22);
    wait_idle();

    // back-to-back with a different divider
    div = 8'd1;
    @(negedge clk);
    b2b_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      send(8'h81 + 8'(i * 37), 1'b1);
      while (!tx_empty) @(negedge clk);
    end
    b2b_en = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    chk(rx_q.size() == 0, "R11 all looped bytes seen", rx_q.size(), 0);

    // overrun
    auto_rd = 1'b0;
    div = 8'd0;
    @(negedge clk);
    send(8'h5A, 1'b0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(rx_full == 1'b1, "R9 full after byte", int'(rx_full), 1);
    chk(rx_ovr == 1'b0, "R10 no overrun yet", int'(rx_ovr), 0);
    send(8'hC3, 1'b0);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(rx_ovr == 1'b1, "R10 overrun set", int'(rx_ovr), 1);
    chk(rx_data == 8'h5A, "R10 new byte discarded", int'(rx_data), 'h5A);
    man_rd = 1'b1; @(negedge clk); man_rd = 1'b0;
    chk(rx_full == 1'b0, "R9 read clears full", int'(rx_full), 0);
    chk(rx_ovr == 1'b1, "R10 overrun sticky", int'(rx_ovr), 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    chk(rx_ovr == 1'b0, "R10 overrun cleared", int'(rx_ovr), 0);
    chk(tx_q.size() == 0 && bitn == 0, "R1 no extra clocks", tx_q.size() + bitn, 0);

    // external clock, bench is the master
    mon_en = 1'b0; loop_en = 1'b0; src = 1'b1;
    repeat (4) @(negedge clk);
    chk(sclk_oe == 1'b0, "R6 clock pin released", int'(sclk_oe), 0);
    chk(sclk == 1'b1, "R6 sclk_o high", int'(sclk), 1);
    poke(8'h96);
    repeat (10) @(negedge clk);
    chk(tx_empty == 1'b0, "R7 held until first fall", int'(tx_empty), 0);
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      automatic logic b = 8'h69 >> i;
      m_sclk = 1'b0; m_rxd = ~b;
      repeat (4) @(negedge clk);
      if (i == 0) chk(tx_empty == 1'b1, "R7 empty after load", int'(tx_empty), 1);
      m_rxd = b;
      repeat (2) @(negedge clk);
      m_sclk = 1'b1; got[i] = txd;
      repeat (4) @(negedge clk);
      m_rxd = ~b;
      repeat (2) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    chk(rx_full == 1'b1, "R6 external byte received", int'(rx_full), 1);
    chk(rx_data == 8'h69, "R3 sampled at rising edge", int'(rx_data), 'h69);
    chk(got == 8'h96, "R6 external transmit", int'(got), 'h96);
    chk(txd == 1'b1, "R4 external holds MSB", int'(txd), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule